// File: doc/BRIEF.md
# Plug-in Slot Interrupt Concentrator

This block collects two interrupt requests from each of four plug-in module slots and merges them into a single active-high host interrupt output. Software controls it through a small 16-bit register bus. Each slot has an 8-bit control register, and one shared status word records the pending state of every source. The status word also holds per-slot timeout flags and a group of error flags.

Each source has its own enable and its own choice of level or edge sensitivity. Level-sensitive sources hold the host line high while any of them is pending. An edge-sensitive source flips the host line for exactly one clock whenever its status bit changes, and the line then returns to its previous value.

Pending sources are retired in two ways. Software can write ones to the status word. The module interrupt-space decoder can send an acknowledge strobe, which retires a pending level-sensitive source.

Top module: `ipc_irq_ctrl`

## Requirements
- R1: After reset, all control registers and the whole status word read 0, and `host_irq` is 0.
- R2: Registers are addressed by a word index (byte offset divided by two). Index 0 and index 5 always read 0, and writes to them change nothing. Indices 1 to 4 are the control registers of slots 0 to 3; they read back the low 8 bits last written, with the upper 8 bits read as 0. Index 6 is the status word.
- R3: A change on a source's request is ignored while that source's enable is clear. The enable of interrupt n of a slot is control bit 6+n.
- R4: While enabled, status bit slot*2+n follows the level of request `mod_irq[slot*2+n]`. The status word is updated at the clock edge where the new request level is first sampled.
- R5: `host_irq` is 1 exactly when some status bit in 7:0 is set whose source is level-sensitive. A source is edge-sensitive when control bit 4+n of its slot is set. Timeout and error bits never drive the line.
- R6: When the status bit of an enabled edge-sensitive source changes, `host_irq` shows the inverse of its level value for one cycle and then returns to it.
- R7: Writing 1 to status bit slot*2+n clears it if that source is enabled. Writing 0 has no effect, and a write to a disabled source's bit has no effect.
- R8: A pulse on `to_evt[s]` sets status bit 12+s. Writing 1 to that bit clears it, and the write wins over a timeout event in the same cycle.
- R9: A pulse on `err_evt[k]` sets status bit 8+k. Writes never clear bits 11:8.
- R10: An acknowledge of slot s, interrupt n clears status bit s*2+n only when that bit is set and the source is enabled and level-sensitive. In every other case the acknowledge changes nothing.
- R11: A status write of 1 to an interrupt bit wins over a request change arriving in the same cycle. The bit stays clear until the request changes again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_widx | input | 3 | Register word index |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_widx` (combinational) |
| mod_irq | input | 8 | Request levels, bit slot*2+n |
| ack_valid | input | 1 | Acknowledge strobe from the interrupt-space decoder |
| ack_slot | input | 2 | Slot being acknowledged |
| ack_int | input | 1 | Interrupt number being acknowledged |
| to_evt | input | 4 | Per-slot timeout event pulses |
| err_evt | input | 4 | Error event pulses |
| host_irq | output | 1 | Host interrupt, active high |

## Verification
A wrong pending bit is visible on the status word one clock after the event that caused it. If its source is level-sensitive, the same wrong bit also shows on `host_irq` in that same cycle. A fault in the edge-sensitivity decode shows up in two ways: a level held where a single-cycle inversion was due, or an inversion where the line should have stayed steady. The bench observes both of these one and two cycles after the change. Priority faults between clears, acknowledges and request changes leave a bit standing on the status word, or missing from it, in the cycle right after the collision.

// File: rtl/ipc_irq_pkg.sv
package ipc_irq_pkg;
   localparam int CTRL_W    = 8;
   localparam int EDGE_LSB  = 4;
   localparam int EN_LSB    = 6;
   localparam int WIDX_REV  = 0;
   localparam int WIDX_CTL0 = 1;

   function automatic int ctrl_widx(input int slot);
      return WIDX_CTL0 + slot;
   endfunction

   function automatic int status_widx(input int nslot);
      return WIDX_CTL0 + nslot + 1;
   endfunction
endpackage

// File: rtl/ipc_irq_ctrl_regs.sv
module ipc_irq_ctrl_regs
   import ipc_irq_pkg::*;
#(
   parameter int NSLOT  = 4,
   parameter int NINT   = 2,
   parameter int WIDX_W = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      reg_wr,
   input  logic [WIDX_W-1:0]         reg_widx,
   input  logic [CTRL_W-1:0]         wbyte,
   output logic [NSLOT*CTRL_W-1:0]   ctrl_flat,
   output logic [NSLOT*NINT-1:0]     en_mask,
   output logic [NSLOT*NINT-1:0]     edge_mask
);
   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      logic [CTRL_W-1:0] ctrl_q;
      logic              sel;
      assign sel = reg_wr && (reg_widx == WIDX_W'(ctrl_widx(s)));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   ctrl_q <= '0;
         else if (sel) ctrl_q <= wbyte;
      end

      assign ctrl_flat[s*CTRL_W +: CTRL_W] = ctrl_q;
      for (genvar n = 0; n < NINT; n++) begin : g_src
         assign en_mask[s*NINT+n]   = ctrl_q[EN_LSB+n];
         assign edge_mask[s*NINT+n] = ctrl_q[EDGE_LSB+n];
      end
   end
endmodule

// File: rtl/ipc_irq_status.sv
module ipc_irq_status #(
   parameter int NSLOT = 4,
   parameter int NINT  = 2,
   parameter int ERR_W = 4,
   localparam int INT_N  = NSLOT*NINT,
   localparam int SLOT_W = $clog2(NSLOT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [INT_N-1:0]  mod_irq,
   input  logic [INT_N-1:0]  en_mask,
   input  logic [INT_N-1:0]  edge_mask,
   input  logic [INT_N-1:0]  clr_int,
   input  logic [NSLOT-1:0]  clr_to,
   input  logic              ack_valid,
   input  logic [SLOT_W-1:0] ack_slot,
   input  logic              ack_int,
   input  logic [NSLOT-1:0]  to_evt,
   input  logic [ERR_W-1:0]  err_evt,
   output logic [INT_N-1:0]  int_q,
   output logic [INT_N-1:0]  int_next,
   output logic [NSLOT-1:0]  to_q,
   output logic [ERR_W-1:0]  err_q
);
   logic [INT_N-1:0] req_q;

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      for (genvar n = 0; n < NINT; n++) begin : g_src
         localparam int IDX = s*NINT + n;
         logic ack_hit, moved, nxt;
         assign ack_hit = ack_valid && (ack_slot == SLOT_W'(s)) && (ack_int == 1'(n))
                          && int_q[IDX] && !edge_mask[IDX];
         assign moved   = mod_irq[IDX] ^ req_q[IDX];
         always_comb begin
            nxt = int_q[IDX];
            if (en_mask[IDX]) begin
               if (clr_int[IDX])  nxt = 1'b0;
               else if (ack_hit)  nxt = 1'b0;
               else if (moved)    nxt = mod_irq[IDX];
            end
         end
         assign int_next[IDX] = nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= '0;
         int_q <= '0;
         to_q  <= '0;
         err_q <= '0;
      end else begin
         req_q <= mod_irq;
         int_q <= int_next;
         to_q  <= (to_q | to_evt) & ~clr_to;
         err_q <= err_q | err_evt;
      end
   end
endmodule

// File: rtl/ipc_irq_line.sv
module ipc_irq_line #(
   parameter int INT_N = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [INT_N-1:0] int_q,
   input  logic [INT_N-1:0] int_next,
   input  logic [INT_N-1:0] edge_mask,
   output logic             host_irq
);
   logic level_q, flip_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= 1'b0;
         flip_q  <= 1'b0;
      end else begin
         level_q <= |(int_next & ~edge_mask);
         flip_q  <= |((int_next ^ int_q) & edge_mask);
      end
   end

   assign host_irq = level_q ^ flip_q;
endmodule

// File: rtl/ipc_irq_ctrl.sv
module ipc_irq_ctrl
   import ipc_irq_pkg::*;
#(
   parameter int NSLOT  = 4,
   parameter int NINT   = 2,
   parameter int ERR_W  = 4,
   parameter int DATA_W = 16,
   parameter int WIDX_W = 3,
   localparam int INT_N  = NSLOT*NINT,
   localparam int SLOT_W = $clog2(NSLOT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [WIDX_W-1:0] reg_widx,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [INT_N-1:0]  mod_irq,
   input  logic              ack_valid,
   input  logic [SLOT_W-1:0] ack_slot,
   input  logic              ack_int,
   input  logic [NSLOT-1:0]  to_evt,
   input  logic [ERR_W-1:0]  err_evt,
   output logic              host_irq
);
   localparam int ERR_LO   = INT_N;
   localparam int TO_LO    = INT_N + ERR_W;
   localparam int STAT_IDX = status_widx(NSLOT);

   if (NINT != 2) begin : g_bad_nint
      $error("ipc_irq_ctrl: control layout holds exactly two sources per slot");
   end
   if (TO_LO + NSLOT != DATA_W) begin : g_bad_layout
      $error("ipc_irq_ctrl: status fields must fill the data word");
   end
   if (STAT_IDX >= (1 << WIDX_W) || NSLOT < 2) begin : g_bad_widx
      $error("ipc_irq_ctrl: word index too narrow or slot count too small");
   end

   logic [NSLOT*CTRL_W-1:0] ctrl_flat;
   logic [INT_N-1:0]        en_mask, edge_mask, int_q, int_next, clr_int;
   logic [NSLOT-1:0]        to_q, clr_to;
   logic [ERR_W-1:0]        err_q;
   logic [DATA_W-1:0]       status_w;
   logic                    stat_wr;
   logic                    err_wr_unused;

   assign stat_wr       = reg_wr && (reg_widx == WIDX_W'(STAT_IDX));
   assign clr_int       = stat_wr ? reg_wdata[INT_N-1:0] : '0;
   assign clr_to        = stat_wr ? reg_wdata[TO_LO +: NSLOT] : '0;
   assign err_wr_unused = ^reg_wdata[ERR_LO +: ERR_W];
   assign status_w      = {to_q, err_q, int_q};

   ipc_irq_ctrl_regs #(.NSLOT(NSLOT), .NINT(NINT), .WIDX_W(WIDX_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_widx(reg_widx),
      .wbyte(reg_wdata[CTRL_W-1:0]), .ctrl_flat(ctrl_flat),
      .en_mask(en_mask), .edge_mask(edge_mask)
   );

   ipc_irq_status #(.NSLOT(NSLOT), .NINT(NINT), .ERR_W(ERR_W)) u_status (
      .clk(clk), .rst_n(rst_n), .mod_irq(mod_irq), .en_mask(en_mask),
      .edge_mask(edge_mask), .clr_int(clr_int), .clr_to(clr_to),
      .ack_valid(ack_valid), .ack_slot(ack_slot), .ack_int(ack_int),
      .to_evt(to_evt), .err_evt(err_evt), .int_q(int_q), .int_next(int_next),
      .to_q(to_q), .err_q(err_q)
   );

   ipc_irq_line #(.INT_N(INT_N)) u_line (
      .clk(clk), .rst_n(rst_n), .int_q(int_q), .int_next(int_next),
      .edge_mask(edge_mask), .host_irq(host_irq)
   );

   always_comb begin
      reg_rdata = '0;
      if (reg_widx == WIDX_W'(STAT_IDX)) reg_rdata = status_w;
      for (int s = 0; s < NSLOT; s++) begin
         if (reg_widx == WIDX_W'(ctrl_widx(s)))
            reg_rdata = DATA_W'(ctrl_flat[s*CTRL_W +: CTRL_W]);
      end
   end
endmodule

// File: rtl/ipc_irq_ctrl_chk.sv
module ipc_irq_ctrl_chk #(
   parameter int NSLOT  = 4,
   parameter int NINT   = 2,
   parameter int ERR_W  = 4,
   parameter int DATA_W = 16,
   parameter int WIDX_W = 3,
   localparam int INT_N = NSLOT*NINT
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [WIDX_W-1:0] reg_widx,
   input logic [DATA_W-1:0] reg_wdata,
   input logic              host_irq,
   input logic [DATA_W-1:0] status_w,
   input logic [INT_N-1:0]  en_mask,
   input logic [INT_N-1:0]  edge_mask
);
   localparam int TO_LO    = INT_N + ERR_W;
   localparam int STAT_IDX = NSLOT + 2;

   logic [INT_N-1:0] st_int;
   logic [ERR_W-1:0] st_err;
   logic [NSLOT-1:0] st_to;
   logic             wr_stat, lvl;

   assign st_int  = status_w[INT_N-1:0];
   assign st_err  = status_w[INT_N +: ERR_W];
   assign st_to   = status_w[TO_LO +: NSLOT];
   assign wr_stat = reg_wr && (reg_widx == WIDX_W'(STAT_IDX));
   assign lvl     = |(st_int & ~edge_mask);

   AST_DISABLED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |-> (((st_int ^ $past(st_int)) & ~$past(en_mask)) == '0)); // R3

   AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      ((((st_int ^ $past(st_int)) & edge_mask) == '0) && $stable(edge_mask))
      |-> (host_irq == lvl)); // R5

   AST_EDGE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
      ((|((st_int ^ $past(st_int)) & edge_mask)) && $stable(edge_mask))
      |-> (host_irq != lvl)); // R6

   AST_TIMEOUT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_stat) |-> ((st_to & $past(reg_wdata[TO_LO +: NSLOT])) == '0)); // R8

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |-> (($past(st_err) & ~st_err) == '0)); // R9
endmodule

bind ipc_irq_ctrl ipc_irq_ctrl_chk #(
   .NSLOT(NSLOT), .NINT(NINT), .ERR_W(ERR_W), .DATA_W(DATA_W), .WIDX_W(WIDX_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_widx(reg_widx),
   .reg_wdata(reg_wdata), .host_irq(host_irq), .status_w(status_w),
   .en_mask(en_mask), .edge_mask(edge_mask)
);

// File: tb/ipc_irq_ctrl_test.sv
module ipc_irq_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_widx = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [7:0]  mod_irq = '0;
   logic        ack_valid = 1'b0;
   logic [1:0]  ack_slot = '0;
   logic        ack_int = 1'b0;
   logic [3:0]  to_evt = '0;
   logic [3:0]  err_evt = '0;
   logic        host_irq;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   localparam logic [2:0] W_STAT = 3'd6;

   always #10 clk = ~clk;

   ipc_irq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_widx(reg_widx),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mod_irq(mod_irq),
      .ack_valid(ack_valid), .ack_slot(ack_slot), .ack_int(ack_int),
      .to_evt(to_evt), .err_evt(err_evt), .host_irq(host_irq)
   );

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr_reg(input logic [2:0] idx, input logic [15:0] data);
      reg_widx = idx; reg_wdata = data; reg_wr = 1'b1;
      step();
      reg_wr = 1'b0;
   endtask

   task automatic rd_chk(input logic [2:0] idx, input logic [15:0] exp, input string tag);
      reg_widx = idx;
      #1;
      check(tag, reg_rdata, exp);
   endtask

   task automatic host_chk(input logic exp, input string tag);
      check(tag, {15'd0, host_irq}, {15'd0, exp});
   endtask

   task automatic ack(input logic [1:0] s, input logic n);
      ack_slot = s; ack_int = n; ack_valid = 1'b1;
      step();
      ack_valid = 1'b0;
   endtask

   initial begin
      #4_000_000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      host_chk(1'b0, "R1 host after reset");
      rd_chk(W_STAT, 16'h0, "R1 status after reset");
      for (int s = 0; s < 4; s++) rd_chk(3'(s + 1), 16'h0, "R1 ctrl after reset");

      // R2: map, revision and reset words
      wr_reg(3'd0, 16'hFFFF);
      rd_chk(3'd0, 16'h0, "R2 revision word");
      wr_reg(3'd5, 16'hFFFF);
      rd_chk(3'd5, 16'h0, "R2 reset word");
      rd_chk(W_STAT, 16'h0, "R2 status untouched");
      for (int s = 0; s < 4; s++) begin
         wr_reg(3'(s + 1), 16'hA500 | 16'(8'h13 * (s + 1)));
         rd_chk(3'(s + 1), 16'(8'h13 * (s + 1)), "R2 ctrl readback");
      end
      for (int s = 0; s < 4; s++) wr_reg(3'(s + 1), 16'h0000);

      // R3: disabled sources ignore requests
      mod_irq = 8'hFF; step();
      rd_chk(W_STAT, 16'h0, "R3 disabled raise");
      host_chk(1'b0, "R3 host stays low");
      mod_irq = 8'h00; step();
      rd_chk(W_STAT, 16'h0, "R3 disabled drop");

      // R4 / R5: level sweep over every source
      for (int s = 0; s < 4; s++) wr_reg(3'(s + 1), 16'h00C0);
      for (int i = 0; i < 8; i++) begin
         mod_irq = 8'(1 << i); step();
         rd_chk(W_STAT, 16'(1 << i), "R4 status follows raise");
         host_chk(1'b1, "R5 level line high");
         mod_irq = 8'h00; step();
         rd_chk(W_STAT, 16'h0, "R4 status follows drop");
         host_chk(1'b0, "R5 level line low");
      end
      mod_irq = 8'hA5; step();
      rd_chk(W_STAT, 16'h00A5, "R4 multi pattern");
      host_chk(1'b1, "R5 multi pattern line");
      mod_irq = 8'h00; step();

      // R6: slot 0 int0 edge, int1 level (ctrl 0xD0)
      wr_reg(3'd1, 16'h00D0);
      mod_irq = 8'h01; step();
      rd_chk(W_STAT, 16'h0001, "R4 edge source status");
      host_chk(1'b1, "R6 pulse from low");
      step();
      host_chk(1'b0, "R6 back to low");
      mod_irq = 8'h03; step();
      host_chk(1'b1, "R5 level beside edge");
      mod_irq = 8'h02; step();
      host_chk(1'b0, "R6 pulse from high");
      step();
      host_chk(1'b1, "R6 back to high");
      mod_irq = 8'h00; step();
      host_chk(1'b0, "R5 level released");
      wr_reg(3'd1, 16'h00C0);

      // R7: write-one clear on slot 1
      mod_irq = 8'h0C; step();
      rd_chk(W_STAT, 16'h000C, "R7 setup");
      wr_reg(W_STAT, 16'h0004);
      rd_chk(W_STAT, 16'h0008, "R7 clear one bit");
      host_chk(1'b1, "R5 remaining source");
      wr_reg(W_STAT, 16'h0000);
      rd_chk(W_STAT, 16'h0008, "R7 zero write no effect");
      wr_reg(W_STAT, 16'h0008);
      rd_chk(W_STAT, 16'h0000, "R7 clear last bit");
      host_chk(1'b0, "R5 line drops after clear");
      mod_irq = 8'h00; step();
      mod_irq = 8'h0C; step();
      wr_reg(3'd2, 16'h0000);
      wr_reg(W_STAT, 16'h000C);
      rd_chk(W_STAT, 16'h000C, "R7 disabled clear ignored");
      wr_reg(3'd2, 16'h00C0);
      wr_reg(W_STAT, 16'h000C);
      rd_chk(W_STAT, 16'h0000, "R7 clear after re-enable");
      mod_irq = 8'h00; step();

      // R10: slot 2, int1 edge (ctrl 0xE0)
      wr_reg(3'd3, 16'h00E0);
      mod_irq = 8'h30; step();
      rd_chk(W_STAT, 16'h0030, "R10 setup");
      ack(2'd2, 1'b0);
      rd_chk(W_STAT, 16'h0020, "R10 level ack clears");
      ack(2'd2, 1'b1);
      rd_chk(W_STAT, 16'h0020, "R10 edge ack ignored");
      ack(2'd3, 1'b0);
      rd_chk(W_STAT, 16'h0020, "R10 ack of idle source ignored");
      mod_irq = 8'h00; step();
      rd_chk(W_STAT, 16'h0000, "R10 cleanup");
      wr_reg(3'd3, 16'h00C0);
      step();

      // R11: clear beats simultaneous raise on slot 3 int0
      mod_irq = 8'h40;
      wr_reg(W_STAT, 16'h0040);
      rd_chk(W_STAT, 16'h0000, "R11 clear wins");
      host_chk(1'b0, "R11 line stays low");
      step();
      rd_chk(W_STAT, 16'h0000, "R11 no re-raise on steady request");
      mod_irq = 8'h00; step();

      // R8: timeouts
      to_evt = 4'b0100; step(); to_evt = 4'b0000;
      rd_chk(W_STAT, 16'h4000, "R8 timeout set");
      host_chk(1'b0, "R5 timeout not on line");
      wr_reg(W_STAT, 16'h4000);
      rd_chk(W_STAT, 16'h0000, "R8 timeout cleared");
      to_evt = 4'b0001;
      wr_reg(W_STAT, 16'h1000);
      to_evt = 4'b0000;
      rd_chk(W_STAT, 16'h0000, "R8 clear wins over event");

      // R9: errors are sticky against writes
      err_evt = 4'b0010; step(); err_evt = 4'b0000;
      rd_chk(W_STAT, 16'h0200, "R9 error set");
      wr_reg(W_STAT, 16'h0F00);
      rd_chk(W_STAT, 16'h0200, "R9 error write ignored");
      host_chk(1'b0, "R5 error not on line");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule